// File: doc/BRIEF.md
# Duplicated Adder Checker with Replay Recovery

This block computes the sum of two operands in two identical copies of an adder. Each copy writes its result into a private result register, and a comparator examines the two registered results in the following cycle. When both registers hold a valid capture and the two values disagree, the block raises an error flag. It withholds the result and re-executes the operands of the faulty cycle from a one-entry save register, then compares again. If a fault lasts several cycles, the block keeps alternating between a report cycle and a re-execution cycle until a comparison comes back clean. Only then does it deliver the result.

An upstream producer presents one operand pair per cycle with a valid strobe and must hold off while the busy output is high. Operands offered during a busy cycle are discarded. A fault-injection input XORs a mask onto the raw output of one adder copy, which the parameter `FAULT_LANE` selects. This stands in for a transient upset of that copy.

The controller has three states. `ST_RUN` is normal streaming. `ST_REPLAY` re-executes the saved operands. `ST_VERIFY` checks the re-executed result. The transitions are:
- RUN to REPLAY on an error.
- RUN to RUN otherwise.
- REPLAY to VERIFY always.
- VERIFY to REPLAY on an error.
- VERIFY to RUN on a clean comparison.

Top module: `dup_check_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `res_valid`, `err_flag` and `recov_busy` are all 0.
- R2: An operand pair accepted in cycle c (in_valid=1 and recov_busy=0) produces `res_valid`=1 in cycle c+1, with `res_data` equal to the (W+1)-bit sum `op_a + op_b`, where bit W is the carry. A new pair can be accepted every cycle.
- R3: When the two copies disagree at a valid capture in cycle t, `err_flag`=1 and `res_valid`=0 in cycle t+1.
- R4: `recov_busy` is 1 in every cycle in which `err_flag` is 1 and in every re-execution cycle. It is 0 in a clean verify cycle and in normal streaming.
- R5: After a report cycle, the next cycle re-executes the saved operands. The comparison of that re-execution appears in the cycle after. For a fault lasting 1 or 2 cycles that starts with a capture in cycle t, the correct sum is committed with `res_valid`=1 in cycle t+3.
- R6: For a fault lasting 3 or 4 cycles, `err_flag` is 1 again in cycle t+3, the saved operands run again in t+4, and the correct sum is committed in t+5.
- R7: Operands presented while `recov_busy` is 1 are ignored. They never produce a result, and the committed sum is that of the originally faulty operands.
- R8: A cycle with in_valid=0 produces no result and no error flag in the next cycle, even when the fault mask is nonzero.
- R9: `fault_mask` (W+1 bits) inverts exactly the set bits of the selected copy's output. Any nonzero mask on a valid capture is flagged, including a mask on the carry bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| fault_mask | input | W+1 | Bits to invert on the selected copy's output this cycle |
| res_data | output | W+1 | Registered sum with carry in the top bit |
| res_valid | output | 1 | res_data is a checked, committed result |
| err_flag | output | 1 | Registered copies disagree this cycle |
| recov_busy | output | 1 | Recovery in progress; inputs are ignored |

## Verification
The bench builds the block with W=8 and FAULT_LANE=1, so the operand 255+255 drives the carry bit and a mask on bit 8 alone can be tested. Directed fault episodes of 1, 2, 3 and 4 cycles reach both the single-replay path and the path where the controller alternates twice between report and re-execution. During every busy cycle, the bench offers junk operands, so a design that accepted them would commit the wrong sum or emit an extra result.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_REPLAY = 2'd1,
        ST_VERIFY = 2'd2
    } dlc_state_t;
endpackage

// File: rtl/dlc_lane.sv
module dlc_lane #(
    parameter int W = 8,
    localparam int RW = W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [RW-1:0] flip,
    output logic [RW-1:0] q
);
    logic [RW-1:0] sum_raw;

    always_comb begin
        sum_raw = ({1'b0, opa} + {1'b0, opb}) ^ flip;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= sum_raw;
    end
endmodule

// File: rtl/dlc_compare.sv
module dlc_compare #(
    parameter int RW = 9
) (
    input  logic [RW-1:0] qa,
    input  logic [RW-1:0] qb,
    input  logic          cap_v,
    output logic          mism
);
    always_comb begin
        mism = cap_v && (qa != qb);
    end
endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
    import dlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mism,
    input  logic       in_valid,
    output dlc_state_t state_q,
    output logic       busy,
    output logic       accept,
    output logic       replay,
    output logic       cap_v_q
);
    dlc_state_t state_d;
    logic       cap_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cap_v_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cap_v_q <= cap_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN:    state_d = mism ? ST_REPLAY : ST_RUN;
            ST_REPLAY: state_d = ST_VERIFY;
            ST_VERIFY: state_d = mism ? ST_REPLAY : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        busy   = 1'b0;
        replay = 1'b0;
        unique case (state_q)
            ST_RUN:    busy = mism;
            ST_REPLAY: begin
                busy   = 1'b1;
                replay = 1'b1;
            end
            ST_VERIFY: busy = mism;
            default:   busy = 1'b0;
        endcase
        accept = in_valid && !busy;
        cap_d  = accept || replay;
    end

    // R5: a reported error is followed by a re-execution cycle
    a_r5_err_to_replay: assert property (@(posedge clk) disable iff (rst)
        mism |=> (state_q == ST_REPLAY));

    // R5: every re-execution is checked in the next cycle
    a_r5_replay_to_verify: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPLAY) |=> (state_q == ST_VERIFY));

    // R6: the verify cycle always compares a real capture
    a_r6_verify_captured: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VERIFY) |-> cap_v_q);
endmodule

// File: rtl/dup_check_top.sv
module dup_check_top
    import dlc_pkg::*;
#(
    parameter int W          = 8,
    parameter int FAULT_LANE = 1,
    localparam int RW    = W + 1,
    localparam int NCOPY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [RW-1:0] fault_mask,
    output logic [RW-1:0] res_data,
    output logic          res_valid,
    output logic          err_flag,
    output logic          recov_busy
);
    dlc_state_t    state_q;
    logic          busy, accept, replay, cap_v_q, mism;
    logic [W-1:0]  save_a, save_b;
    logic [W-1:0]  exec_a, exec_b;
    logic [RW-1:0] lane_q [NCOPY];

    dlc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mism     (mism),
        .in_valid (in_valid),
        .state_q  (state_q),
        .busy     (busy),
        .accept   (accept),
        .replay   (replay),
        .cap_v_q  (cap_v_q)
    );

    // one-entry save of the last accepted operands
    always_ff @(posedge clk) begin
        if (rst) begin
            save_a <= '0;
            save_b <= '0;
        end else if (accept) begin
            save_a <= op_a;
            save_b <= op_b;
        end
    end

    always_comb begin
        exec_a = replay ? save_a : op_a;
        exec_b = replay ? save_b : op_b;
    end

    for (genvar i = 0; i < NCOPY; i++) begin : g_lane
        logic [RW-1:0] flip_i;
        if (i == FAULT_LANE) begin : g_hit
            assign flip_i = fault_mask;
        end else begin : g_clean
            assign flip_i = '0;
        end
        dlc_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .opa  (exec_a),
            .opb  (exec_b),
            .flip (flip_i),
            .q    (lane_q[i])
        );
    end

    dlc_compare #(.RW(RW)) u_cmp (
        .qa    (lane_q[0]),
        .qb    (lane_q[1]),
        .cap_v (cap_v_q),
        .mism  (mism)
    );

    always_comb begin
        res_data   = lane_q[0];
        res_valid  = cap_v_q && !mism;
        err_flag   = mism;
        recov_busy = busy;
    end

    // R1: clean outputs in the first cycle after reset
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !err_flag && !recov_busy));

    // R3: a failed comparison never delivers a result
    a_r3_err_no_valid: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !res_valid);

    // R7: saved operands stay put while recovery is running
    a_r7_save_hold: assert property (@(posedge clk) disable iff (rst)
        recov_busy |=> ($stable(save_a) && $stable(save_b)));

    // R4: a reported error keeps the block busy into the re-execution
    a_r4_busy_through_replay: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> recov_busy);
endmodule

// File: tb/sim_dup_check_top.sv
module sim_dup_check_top;
    localparam int CLK_PER = 10;
    localparam int W  = 8;
    localparam int RW = W + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic [RW-1:0] fault_mask = '0;
    logic [RW-1:0] res_data;
    logic          res_valid, err_flag, recov_busy;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PER/2) clk = ~clk;

    dup_check_top #(.W(W), .FAULT_LANE(1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .fault_mask(fault_mask), .res_data(res_data), .res_valid(res_valid),
        .err_flag(err_flag), .recov_busy(recov_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [RW-1:0] m);
        in_valid = v; op_a = a; op_b = b; fault_mask = m;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid in reset", res_valid, 0);
        chk("R1 busy in reset", recov_busy, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", res_valid, 0);
        chk("R1 err after reset", err_flag, 0);
        chk("R1 busy after reset", recov_busy, 0);
    endtask

    task automatic t_stream();
        logic [W-1:0] av [5] = '{8'd3, 8'd255, 8'd0, 8'd128, 8'd200};
        logic [W-1:0] bv [5] = '{8'd4, 8'd255, 8'd0, 8'd127, 8'd100};
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, av[i], bv[i], '0);
            chk("R2 valid", res_valid, 1);
            chk("R2 sum", res_data, av[i] + bv[i]);
            chk("R4 busy streaming", recov_busy, 0);
        end
        drive(1'b0, 8'd0, 8'd0, '0);
        chk("R2 no valid after stream", res_valid, 0);
    endtask

    task automatic t_idle();
        drive(1'b0, 8'd5, 8'd6, '0);
        chk("R8 idle valid", res_valid, 0);
        drive(1'b0, 8'd1, 8'd2, 9'h001);
        chk("R8 masked idle err", err_flag, 0);
        chk("R8 masked idle valid", res_valid, 0);
    endtask

    task automatic t_fault(input int dur, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [RW-1:0] m);
        int commit;
        logic e_err, e_busy;
        string tg;
        commit = (dur <= 2) ? 3 : 5;
        tg = (dur <= 2) ? "R5" : "R6";
        drive(1'b1, a, b, m);
        for (int k = 1; k <= 6; k++) begin
            e_err  = (k == 1) || (k == 3 && dur >= 3);
            e_busy = e_err || (k == 2) || (k == 4 && dur >= 3);
            chk({tg, " R3 err"}, err_flag, e_err);
            chk({tg, " R4 busy"}, recov_busy, e_busy);
            chk({tg, " R7 valid"}, res_valid, (k == commit));
            if (k == commit) chk({tg, " R9 committed sum"}, res_data, a + b);
            // junk operands offered while busy must be dropped
            drive(e_busy, a ^ 8'h5A, b ^ 8'hC3, (k < dur) ? m : '0);
        end
    endtask

    initial begin
        #(CLK_PER * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_idle();
        t_fault(1, 8'd17, 8'd42, 9'h001);
        t_fault(2, 8'd255, 8'd255, 9'h100);
        t_fault(3, 8'd100, 8'd99, 9'h1FF);
        t_fault(4, 8'd7, 8'd250, 9'h010);
        t_stream();
        summary();
        $finish;
    end
endmodule